// File: doc/BRIEF.md
# I2C Master Transmit Controller

This block drives an I2C bus as a master that only sends. It is paced one byte at a time by software through a small register file. Software enables the block and asks for a START. It loads a data register with the address byte or a data byte and then reads a status code after each bus event. Each event raises an interrupt flag. The block holds SCL low until software clears that flag, and the bus stands still while software decides what comes next. With the flag cleared, software can ask for a repeated START, a STOP, or the next byte.

SCL low and high phases are timed by two count registers that are written separately. The high phase is counted only while the SCL line is actually seen high, so a slave that stretches the clock lengthens it. If the block drives a 1 on SDA but sees 0 while sending, it reports a lost arbitration, lets go of both lines and goes idle.

Top module: `i2c_mtx_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 and the status register reads 0xF8 (idle). SCL and SDA are both released, with scl_oe = 0 and sda_oe = 0.
- R2: Register addresses:
  - 0: write sets control bits, read returns the control register.
  - 1: write clears control bits.
  - 2: data.
  - 3: status, read only.
  - 4: SCL low count.
  - 5: SCL high count.

  Control bits are enable 6, start request 5, stop request 4, interrupt flag 3 and acknowledge 2. A write to address 0 only sets the bits written as 1, and a write to address 1 only clears the bits written as 1. Bits 7, 1 and 0 always read 0.
- R3: A START is issued when enable and start request are 1, the flag is 0 and both lines are high. SDA falls while SCL is high. Then the flag is set, the status reads 0x08 and the start request is cleared by hardware. With enable at 0, a start request has no effect: the bus stays released, the status stays 0xF8 and the flag stays 0.
- R4: While the flag is set after a bus event, SCL is held low and the status does not change.
- R5: When the flag is cleared, with no stop or start request pending, the data register is sent MSB first and then a ninth clock samples ACK. For the first byte after a START or repeated START the status is 0x18 on ACK (SDA low) and 0x20 on NACK, and the flag is set.
- R6: For later bytes the status is 0x28 on ACK and 0x30 on NACK.
- R7: A start request pending when the flag is cleared gives a repeated START. SDA is released during SCL low, then SCL rises, then SDA falls. The status then reads 0x10, and the next byte reports 0x18 or 0x20.
- R8: A stop request pending when the flag is cleared gives a STOP, and it takes priority over a start request. SDA rises while SCL is high. The block then clears the stop request, leaves the flag at 0, shows status 0xF8 and releases both lines. A start request that is still set is served afterwards with a new START.
- R9: If SDA reads 0 at the end of an SCL high phase in which the block sends a 1 data bit, the status becomes 0x38. The flag is set, both lines are released and the block goes idle.
- R10: With no clock stretching, each SCL low phase inside a byte lasts (low count + 1) clock cycles and each high phase lasts (high count + 1) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| scl_i | input | 1 | Sensed SCL line level, already synchronized |
| sda_i | input | 1 | Sensed SDA line level, already synchronized |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench sends the address byte and data bytes against a slave model that can ACK or NACK. It checks each status code.

- A design that mixes up the first-byte and later-byte codes would report 0x28 for an address, or 0x18 for data.
- A repeated START forms the edge on the wrong phase if SDA is not released during SCL low first. The slave model would then never count a second START.
- A STOP requested together with a START checks priority and auto-clear. A design that served the start first, or left the stop bit set, would show the wrong status or lines held low when the stop bit drops.
- Changing the SCL counts between bytes would show up a timer that ignores one register or counts one cycle wrong.
- A forced-low SDA on a 1 bit checks that arbitration loss releases the bus rather than stalling it.

// File: rtl/i2c_mtx_pkg.sv
package i2c_mtx_pkg;

    localparam int BIT_EN  = 6;
    localparam int BIT_STA = 5;
    localparam int BIT_STO = 4;
    localparam int BIT_SI  = 3;
    localparam int BIT_AA  = 2;

    localparam int ADR_SET  = 0;
    localparam int ADR_CLR  = 1;
    localparam int ADR_DATA = 2;
    localparam int ADR_STAT = 3;
    localparam int ADR_LO   = 4;
    localparam int ADR_HI   = 5;

    localparam logic [7:0] ST_START   = 8'h08;
    localparam logic [7:0] ST_RESTART = 8'h10;
    localparam logic [7:0] ST_ADR_ACK = 8'h18;
    localparam logic [7:0] ST_ADR_NAK = 8'h20;
    localparam logic [7:0] ST_DAT_ACK = 8'h28;
    localparam logic [7:0] ST_DAT_NAK = 8'h30;
    localparam logic [7:0] ST_ARB     = 8'h38;
    localparam logic [7:0] ST_IDLE    = 8'hF8;

    typedef enum logic [3:0] {
        E_IDLE, E_START, E_HOLD, E_BIT_LO, E_BIT_HI,
        E_RS_LO, E_RS_HI, E_STP_LO, E_STP_HI, E_STP_END
    } eng_st_e;

endpackage

// File: rtl/i2c_mtx_regs.sv
module i2c_mtx_regs
    import i2c_mtx_pkg::*;
#(
    parameter int AW     = 3,
    parameter int CW     = 8,
    parameter int DEF_LO = 4,
    parameter int DEF_HI = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic [7:0]    status,
    input  logic          hw_set_si,
    input  logic          hw_clr_sta,
    input  logic          hw_clr_sto,
    output logic          en,
    output logic          sta,
    output logic          sto,
    output logic          si,
    output logic [7:0]    data,
    output logic [CW-1:0] lo_cnt,
    output logic [CW-1:0] hi_cnt
);

    typedef struct packed {
        logic          en;
        logic          sta;
        logic          sto;
        logic          si;
        logic          aa;
        logic [7:0]    data;
        logic [CW-1:0] lo;
        logic [CW-1:0] hi;
    } regs_t;

    regs_t r_d, r_q;
    logic [7:0] ctrl_view;

    always_comb begin
        r_d = r_q;
        if (wr && addr == AW'(ADR_SET)) begin
            r_d.en  = r_q.en  | wdata[BIT_EN];
            r_d.sta = r_q.sta | wdata[BIT_STA];
            r_d.sto = r_q.sto | wdata[BIT_STO];
            r_d.si  = r_q.si  | wdata[BIT_SI];
            r_d.aa  = r_q.aa  | wdata[BIT_AA];
        end
        if (wr && addr == AW'(ADR_CLR)) begin
            r_d.en  = r_q.en  & ~wdata[BIT_EN];
            r_d.sta = r_q.sta & ~wdata[BIT_STA];
            r_d.sto = r_q.sto & ~wdata[BIT_STO];
            r_d.si  = r_q.si  & ~wdata[BIT_SI];
            r_d.aa  = r_q.aa  & ~wdata[BIT_AA];
        end
        if (wr && addr == AW'(ADR_DATA)) r_d.data = wdata;
        if (wr && addr == AW'(ADR_LO))   r_d.lo   = wdata[CW-1:0];
        if (wr && addr == AW'(ADR_HI))   r_d.hi   = wdata[CW-1:0];
        // hardware events take precedence over a same-cycle software write
        if (hw_set_si)  r_d.si  = 1'b1;
        if (hw_clr_sta) r_d.sta = 1'b0;
        if (hw_clr_sto) r_d.sto = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{en: 1'b0, sta: 1'b0, sto: 1'b0, si: 1'b0, aa: 1'b0,
                     data: 8'h00, lo: CW'(DEF_LO), hi: CW'(DEF_HI)};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        ctrl_view          = 8'h00;
        ctrl_view[BIT_EN]  = r_q.en;
        ctrl_view[BIT_STA] = r_q.sta;
        ctrl_view[BIT_STO] = r_q.sto;
        ctrl_view[BIT_SI]  = r_q.si;
        ctrl_view[BIT_AA]  = r_q.aa;
        rdata = 8'h00;
        if (addr == AW'(ADR_SET) || addr == AW'(ADR_CLR)) rdata = ctrl_view;
        if (addr == AW'(ADR_DATA)) rdata = r_q.data;
        if (addr == AW'(ADR_STAT)) rdata = status;
        if (addr == AW'(ADR_LO))   rdata = 8'(r_q.lo);
        if (addr == AW'(ADR_HI))   rdata = 8'(r_q.hi);
    end

    assign en     = r_q.en;
    assign sta    = r_q.sta;
    assign sto    = r_q.sto;
    assign si     = r_q.si;
    assign data   = r_q.data;
    assign lo_cnt = r_q.lo;
    assign hi_cnt = r_q.hi;

    // R5: an event posted by the engine shows up as the flag one cycle later
    p_flag_posted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set_si |=> r_q.si);

    // R8: stop request is gone after the engine finishes a STOP
    p_stop_autoclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr_sto |=> !r_q.sto);

endmodule

// File: rtl/i2c_mtx_engine.sv
module i2c_mtx_engine
    import i2c_mtx_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          sta,
    input  logic          sto,
    input  logic          si,
    input  logic [7:0]    data,
    input  logic [CW-1:0] lo_cnt,
    input  logic [CW-1:0] hi_cnt,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          set_si,
    output logic          clr_sta,
    output logic          clr_sto,
    output logic [7:0]    status
);

    localparam int BIW = 4;
    localparam logic [BIW-1:0] ACK_SLOT = BIW'(8);

    typedef struct packed {
        eng_st_e        st;
        logic [CW-1:0]  cnt;
        logic [BIW-1:0] bidx;
        logic [7:0]     sh;
        logic [7:0]     stat;
        logic           first;
        logic           rep;
    } eng_t;

    eng_t e_d, e_q;
    logic cnt_zero;
    logic drive_bit;

    assign cnt_zero  = (e_q.cnt == '0);
    assign drive_bit = (e_q.bidx != ACK_SLOT) && !e_q.sh[7];

    always_comb begin
        e_d     = e_q;
        set_si  = 1'b0;
        clr_sta = 1'b0;
        clr_sto = 1'b0;
        if (!en) begin
            e_d.st = E_IDLE;
        end else begin
            case (e_q.st)
                E_IDLE: begin
                    if (sta && !si && scl_i && sda_i) begin
                        e_d.st  = E_START;
                        e_d.cnt = hi_cnt;
                        e_d.rep = 1'b0;
                    end
                end
                E_START: begin
                    if (scl_i) begin
                        if (cnt_zero) begin
                            set_si      = 1'b1;
                            clr_sta     = 1'b1;
                            e_d.stat    = e_q.rep ? ST_RESTART : ST_START;
                            e_d.first   = 1'b1;
                            e_d.st      = E_HOLD;
                        end else begin
                            e_d.cnt = e_q.cnt - 1'b1;
                        end
                    end
                end
                E_HOLD: begin
                    if (!si) begin
                        e_d.cnt = lo_cnt;
                        if (sto) begin
                            e_d.st = E_STP_LO;
                        end else if (sta) begin
                            e_d.st = E_RS_LO;
                        end else begin
                            e_d.st   = E_BIT_LO;
                            e_d.sh   = data;
                            e_d.bidx = '0;
                        end
                    end
                end
                E_BIT_LO, E_RS_LO, E_STP_LO: begin
                    if (cnt_zero) begin
                        e_d.cnt = hi_cnt;
                        case (e_q.st)
                            E_BIT_LO: e_d.st = E_BIT_HI;
                            E_RS_LO:  e_d.st = E_RS_HI;
                            default:  e_d.st = E_STP_HI;
                        endcase
                    end else begin
                        e_d.cnt = e_q.cnt - 1'b1;
                    end
                end
                E_BIT_HI: begin
                    if (scl_i) begin
                        if (!cnt_zero) begin
                            e_d.cnt = e_q.cnt - 1'b1;
                        end else if (e_q.bidx == ACK_SLOT) begin
                            set_si    = 1'b1;
                            e_d.first = 1'b0;
                            e_d.st    = E_HOLD;
                            if (e_q.first) e_d.stat = sda_i ? ST_ADR_NAK : ST_ADR_ACK;
                            else           e_d.stat = sda_i ? ST_DAT_NAK : ST_DAT_ACK;
                        end else if (e_q.sh[7] && !sda_i) begin
                            set_si   = 1'b1;
                            e_d.stat = ST_ARB;
                            e_d.st   = E_IDLE;
                        end else begin
                            e_d.sh   = {e_q.sh[6:0], 1'b0};
                            e_d.bidx = e_q.bidx + 1'b1;
                            e_d.cnt  = lo_cnt;
                            e_d.st   = E_BIT_LO;
                        end
                    end
                end
                E_RS_HI: begin
                    if (scl_i) begin
                        if (cnt_zero) begin
                            e_d.st  = E_START;
                            e_d.cnt = hi_cnt;
                            e_d.rep = 1'b1;
                        end else begin
                            e_d.cnt = e_q.cnt - 1'b1;
                        end
                    end
                end
                E_STP_HI: begin
                    if (scl_i) begin
                        if (cnt_zero) begin
                            e_d.st  = E_STP_END;
                            e_d.cnt = hi_cnt;
                        end else begin
                            e_d.cnt = e_q.cnt - 1'b1;
                        end
                    end
                end
                E_STP_END: begin
                    if (cnt_zero) begin
                        clr_sto  = 1'b1;
                        e_d.stat = ST_IDLE;
                        e_d.st   = E_IDLE;
                    end else begin
                        e_d.cnt = e_q.cnt - 1'b1;
                    end
                end
                default: e_d.st = E_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{st: E_IDLE, cnt: '0, bidx: '0, sh: 8'h00,
                     stat: ST_IDLE, first: 1'b0, rep: 1'b0};
        end else begin
            e_q <= e_d;
        end
    end

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        case (e_q.st)
            E_START:   begin scl_oe = 1'b0; sda_oe = 1'b1;      end
            E_HOLD:    begin scl_oe = 1'b1; sda_oe = 1'b0;      end
            E_BIT_LO:  begin scl_oe = 1'b1; sda_oe = drive_bit; end
            E_BIT_HI:  begin scl_oe = 1'b0; sda_oe = drive_bit; end
            E_RS_LO:   begin scl_oe = 1'b1; sda_oe = 1'b0;      end
            E_STP_LO:  begin scl_oe = 1'b1; sda_oe = 1'b1;      end
            E_STP_HI:  begin scl_oe = 1'b0; sda_oe = 1'b1;      end
            default:   begin scl_oe = 1'b0; sda_oe = 1'b0;      end
        endcase
    end

    assign status = e_q.stat;

    // R3: disabling releases the bus on the next cycle
    p_disable_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_oe && !sda_oe));

    // R3, R7: a completed START reports one of the two start codes
    p_start_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == E_START && set_si) |=> (status == ST_START || status == ST_RESTART));

    // R4: while the flag is pending the engine stays put with SCL low
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == E_HOLD && si && en) |=> (e_q.st == E_HOLD && scl_oe));

    // R5: the ninth clock of a first byte reports an address code
    p_addr_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == E_BIT_HI && set_si && e_q.first && e_q.bidx == ACK_SLOT)
        |=> (status == ST_ADR_ACK || status == ST_ADR_NAK));

    // R9: a lost bit releases both lines and reports arbitration loss
    p_arb_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == E_BIT_HI && set_si && e_q.bidx != ACK_SLOT)
        |=> (!scl_oe && !sda_oe && status == ST_ARB));

endmodule

// File: rtl/i2c_mtx_ctrl.sv
module i2c_mtx_ctrl
    import i2c_mtx_pkg::*;
#(
    parameter int AW     = 3,
    parameter int CW     = 8,
    parameter int DEF_LO = 4,
    parameter int DEF_HI = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe
);

    logic          en, sta, sto, si;
    logic [7:0]    data;
    logic [CW-1:0] lo_cnt, hi_cnt;
    logic          set_si, clr_sta, clr_sto;
    logic [7:0]    status;

    i2c_mtx_regs #(.AW(AW), .CW(CW), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .status     (status),
        .hw_set_si  (set_si),
        .hw_clr_sta (clr_sta),
        .hw_clr_sto (clr_sto),
        .en         (en),
        .sta        (sta),
        .sto        (sto),
        .si         (si),
        .data       (data),
        .lo_cnt     (lo_cnt),
        .hi_cnt     (hi_cnt)
    );

    i2c_mtx_engine #(.CW(CW)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .sta     (sta),
        .sto     (sto),
        .si      (si),
        .data    (data),
        .lo_cnt  (lo_cnt),
        .hi_cnt  (hi_cnt),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe),
        .set_si  (set_si),
        .clr_sta (clr_sta),
        .clr_sto (clr_sto),
        .status  (status)
    );

endmodule

// File: tb/sim_i2c_mtx_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_mtx_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe;
    logic       slv_drv = 1'b0;
    logic       arb_pull = 1'b0;
    logic       nack_mode = 1'b0;
    logic       scl_line, sda_line;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int starts = 0;
    int stops = 0;
    logic [7:0] rx_sh = 8'h00;
    logic [7:0] got_byte = 8'h00;
    int kbit = 0;

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | slv_drv | arb_pull);

    always #2.5 clk = ~clk;

    i2c_mtx_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    // slave model: counts START/STOP, captures bytes, answers on the ninth clock
    logic p_scl = 1'b1, p_sda = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_scl && scl_line && p_sda && !sda_line) begin starts++; kbit = 0; end
            if (p_scl && scl_line && !p_sda && sda_line) stops++;
            if (!p_scl && scl_line) begin
                kbit++;
                if (kbit <= 8) rx_sh = {rx_sh[6:0], sda_line};
                if (kbit == 8) got_byte = rx_sh;
            end
            if (p_scl && !scl_line) begin
                if (kbit == 8 && !nack_mode) slv_drv = 1'b1;
                if (kbit == 9) begin slv_drv = 1'b0; kbit = 0; end
            end
        end
        p_scl = scl_line;
        p_sda = sda_line;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, act=%0d exp<150000 cycles", cycles);
            summary();
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_flag(input string req);
        logic [7:0] c;
        int n = 0;
        c = 8'h00;
        while (n < 4000) begin
            @(negedge clk);
            rd_reg(3'd0, c);
            if (c[3]) break;
            n++;
        end
        check(c[3] == 1'b1, req, c, 8'h08);
    endtask

    task automatic measure(input int exp_hi, input int exp_lo, input string req);
        int h = 0;
        int l = 0;
        int guard = 0;
        while (!scl_line && guard < 4000) begin @(negedge clk); guard++; end
        while (scl_line && guard < 4000) begin h++; @(negedge clk); guard++; end
        while (!scl_line && guard < 4000) begin l++; @(negedge clk); guard++; end
        check(h == exp_hi, req, h, exp_hi);
        check(l == exp_lo, req, l, exp_lo);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        @(negedge clk);
        rd_reg(3'd0, v); check(v == 8'h00, "R1 ctrl", v, 8'h00);
        rd_reg(3'd3, v); check(v == 8'hF8, "R1 status", v, 8'hF8);
        check(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr_reg(3'd0, 8'hFF);
        rd_reg(3'd0, v); check(v == 8'h7C, "R2 set all, reserved zero", v, 8'h7C);
        wr_reg(3'd1, 8'hFF);
        rd_reg(3'd0, v); check(v == 8'h00, "R2 clear all", v, 8'h00);
        wr_reg(3'd0, 8'h44);
        wr_reg(3'd0, 8'h08);
        rd_reg(3'd0, v); check(v == 8'h4C, "R2 set only", v, 8'h4C);
        wr_reg(3'd1, 8'h08);
        rd_reg(3'd0, v); check(v == 8'h44, "R2 clear only", v, 8'h44);
        wr_reg(3'd2, 8'h96);
        rd_reg(3'd2, v); check(v == 8'h96, "R2 data", v, 8'h96);
        wr_reg(3'd4, 8'd5);
        wr_reg(3'd5, 8'd3);
        rd_reg(3'd4, v); check(v == 8'd5, "R2 low count", v, 5);
        rd_reg(3'd5, v); check(v == 8'd3, "R2 high count", v, 3);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        wr_reg(3'd1, 8'h40);
        wr_reg(3'd0, 8'h20);
        repeat (40) @(negedge clk);
        rd_reg(3'd3, v); check(v == 8'hF8, "R3 disabled status", v, 8'hF8);
        rd_reg(3'd0, v); check(v[3] == 1'b0, "R3 disabled flag", v, 8'h20);
        check(!scl_oe && !sda_oe && starts == 0, "R3 disabled bus", starts, 0);
        wr_reg(3'd1, 8'h20);
    endtask

    task automatic t_start();
        logic [7:0] v;
        wr_reg(3'd0, 8'h44);
        wr_reg(3'd0, 8'h20);
        wait_flag("R3 start flag");
        rd_reg(3'd3, v); check(v == 8'h08, "R3 start status", v, 8'h08);
        rd_reg(3'd0, v); check(v[5] == 1'b0, "R3 sta auto clear", v, 8'h4C);
        check(starts == 1, "R3 start seen on bus", starts, 1);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        int high_seen = 0;
        repeat (60) begin
            @(negedge clk);
            if (scl_line) high_seen++;
        end
        check(high_seen == 0, "R4 scl held low", high_seen, 0);
        rd_reg(3'd3, v); check(v == 8'h08, "R4 status stable", v, 8'h08);
    endtask

    task automatic t_byte(input logic [7:0] b, input logic nk, input logic [7:0] exp_st,
                          input string req);
        logic [7:0] v;
        nack_mode = nk;
        wr_reg(3'd2, b);
        wr_reg(3'd1, 8'h08);
        wait_flag(req);
        rd_reg(3'd3, v); check(v == exp_st, req, v, exp_st);
        check(got_byte == b, req, got_byte, b);
        nack_mode = 1'b0;
    endtask

    task automatic t_addr_timed();
        logic [7:0] v;
        wr_reg(3'd2, 8'hA4);
        wr_reg(3'd1, 8'h08);
        measure(4, 6, "R10 counts 5/3");
        wait_flag("R5 address flag");
        rd_reg(3'd3, v); check(v == 8'h18, "R5 address ACK status", v, 8'h18);
        check(got_byte == 8'hA4, "R5 address bits MSB first", got_byte, 8'hA4);
    endtask

    task automatic t_restart();
        logic [7:0] v;
        wr_reg(3'd0, 8'h20);
        wr_reg(3'd1, 8'h08);
        wait_flag("R7 restart flag");
        rd_reg(3'd3, v); check(v == 8'h10, "R7 restart status", v, 8'h10);
        check(starts == 2, "R7 restart seen on bus", starts, 2);
        t_byte(8'h5A, 1'b1, 8'h20, "R7 address NACK after restart");
    endtask

    task automatic t_stop();
        logic [7:0] c, s;
        int n = 0;
        c = 8'h10;
        s = 8'h00;
        wr_reg(3'd0, 8'h30);
        wr_reg(3'd1, 8'h08);
        while (n < 4000) begin
            @(negedge clk);
            rd_reg(3'd0, c);
            if (!c[4]) break;
            n++;
        end
        rd_reg(3'd3, s);
        check(c[4] == 1'b0 && c[3] == 1'b0, "R8 sto cleared, flag low", c, 8'h60);
        check(s == 8'hF8, "R8 idle status after stop", s, 8'hF8);
        check(scl_line && sda_line, "R8 bus released", {scl_line, sda_line}, 3);
        check(stops == 1, "R8 stop seen on bus", stops, 1);
        wait_flag("R8 queued start flag");
        rd_reg(3'd3, s); check(s == 8'h08, "R8 queued start status", s, 8'h08);
    endtask

    task automatic t_retime();
        logic [7:0] v;
        wr_reg(3'd4, 8'd2);
        wr_reg(3'd5, 8'd7);
        wr_reg(3'd2, 8'h81);
        wr_reg(3'd1, 8'h08);
        measure(8, 3, "R10 counts 2/7");
        wait_flag("R10 byte flag");
        rd_reg(3'd3, v); check(v == 8'h18, "R10 byte status", v, 8'h18);
    endtask

    task automatic t_arb();
        logic [7:0] v;
        wr_reg(3'd2, 8'hFF);
        arb_pull = 1'b1;
        wr_reg(3'd1, 8'h08);
        wait_flag("R9 arbitration flag");
        rd_reg(3'd3, v); check(v == 8'h38, "R9 arbitration status", v, 8'h38);
        repeat (20) @(negedge clk);
        check(!scl_oe && !sda_oe, "R9 bus released", {scl_oe, sda_oe}, 0);
        arb_pull = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_disabled();
        t_start();
        t_hold();
        t_addr_timed();
        t_byte(8'h3C, 1'b0, 8'h28, "R6 data ACK");
        t_byte(8'hC3, 1'b1, 8'h30, "R6 data NACK");
        t_restart();
        t_stop();
        t_retime();
        t_arb();
        summary();
    end

endmodule